// File: doc/BRIEF.md
# Triggered Waveform Capture Controller

This block sits between a digitizer's sample stream and a capture memory. It waits in its idle state until a trigger pulse arrives from the test sequencer. When it accepts a trigger, it latches three values: a discard count, a first address and a total store count. It then drops the given number of leading valid samples. After that it writes exactly the store count of valid samples into consecutive memory locations, starting at the first address. When the last sample is written, it reports the final address it wrote.

The block runs entirely on the sample clock. The trigger comes from another clock domain, so it passes through a two-flop synchronizer, and its rising edge is detected in the sample domain.

The controller has four named states:
- `CAP_IDLE`: the state after reset.
- `CAP_DISCARD`: dropping leading samples.
- `CAP_STORE`: writing samples to memory.
- `CAP_DONE`: capture finished; the result is held.

Its transitions are:
- **accept**: from IDLE or DONE on a synchronized trigger edge. It goes to DISCARD if the discard count is non-zero. Otherwise it goes to STORE, or straight to DONE if the store count is zero.
- **skip_end**: from DISCARD to STORE on the valid sample that uses up the discard count.
- **store_end**: from STORE to DONE on the valid sample that uses up the store count.

Top module: `wave_capture_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0 and `last_addr` is 0.
- R2: A rising edge of `trig_in` is seen through a two-flop synchronizer and an edge register. In IDLE or DONE, that edge starts a capture. `busy` (or `done`, for a zero store count) is high no later than 4 sample clocks after the edge.
- R3: The first `skip_cnt` valid samples after acceptance are never written to memory.
- R4: Each later valid sample is written, one clock after it is presented, with `mem_we`=1. The write goes to the next ascending address, starting at `first_addr`. Cycles with `smp_valid`=0 neither write nor advance the address.
- R5: Exactly `store_cnt` writes happen per capture.
- R6: Addresses wrap modulo 2^AW (64 by default). The location after address 63 is 0.
- R7: In DONE, `last_addr` equals (first_addr + store_cnt - 1) mod 2^AW. For a zero store count it equals `first_addr`.
- R8: A store count of 0 moves the block directly to DONE, with no write.
- R9: A trigger edge while `busy` is high is ignored. Config inputs changed at that time have no effect on the running capture.
- R10: `done` stays high, and valid samples in DONE cause no write, until the next accepted trigger. A trigger with a non-zero store count clears `done`.
- R11: `busy` and `done` are never high together. `busy` is low once `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| trig_in | input | 1 | Trigger from the sequencer clock domain (asynchronous) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| skip_cnt | input | CW | Number of leading samples to drop |
| first_addr | input | AW | Memory address of the first stored sample |
| store_cnt | input | CW | Number of samples to store |
| mem_addr | output | AW | Capture memory write address |
| mem_data | output | DW | Capture memory write data |
| mem_we | output | 1 | Capture memory write enable |
| busy | output | 1 | Capture in progress (DISCARD or STORE) |
| done | output | 1 | Capture finished, result held |
| last_addr | output | AW | Last address written by the latest capture |

## Verification
A corrupted discard counter appears as shifted memory contents. The memory contents are checked in full when `done` rises. A corrupted store counter appears as a wrong write total, or as `done` never rising. An address register that fails to wrap, or that advances on invalid cycles, appears on `mem_addr` one clock after the faulty sample, and as mismatched cells at the end. A trigger that leaks through while busy restarts the counters, so the write total and the contents are wrong within that same capture.

// File: rtl/wave_capture_pkg.sv
package wave_capture_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_DISCARD = 2'd1,
        CAP_STORE   = 2'd2,
        CAP_DONE    = 2'd3
    } cap_state_t;
endpackage

// File: rtl/wave_trig_sync.sv
module wave_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    logic [STAGES-1:0] sync_q;
    logic              edge_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            edge_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_async};
            edge_q <= sync_q[STAGES-1];
        end
    end

    assign trig_rise = sync_q[STAGES-1] & ~edge_q;

    // R2: an edge pulse lasts exactly one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);
endmodule

// File: rtl/wave_capture_fsm.sv
module wave_capture_fsm
    import wave_capture_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_rise,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic [CW-1:0] skip_in,
    input  logic [AW-1:0] first_in,
    input  logic [CW-1:0] count_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] last_addr
);
    localparam logic [CW-1:0] ONE = CW'(1);

    cap_state_t    st, st_nx;
    logic [CW-1:0] skip_left;
    logic [CW-1:0] store_left;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] base_addr;
    logic          accept;

    assign accept = trig_rise && (st == CAP_IDLE || st == CAP_DONE);

    always_comb begin
        st_nx = st;
        unique case (st)
            CAP_IDLE, CAP_DONE: begin
                if (accept) begin
                    if (count_in == '0)     st_nx = CAP_DONE;
                    else if (skip_in != '0) st_nx = CAP_DISCARD;
                    else                    st_nx = CAP_STORE;
                end
            end
            CAP_DISCARD: if (smp_valid && skip_left == ONE)  st_nx = CAP_STORE;
            CAP_STORE:   if (smp_valid && store_left == ONE) st_nx = CAP_DONE;
            default:     st_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CAP_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_left  <= '0;
            store_left <= '0;
            wr_addr    <= '0;
            base_addr  <= '0;
            mem_addr   <= '0;
            mem_data   <= '0;
            mem_we     <= 1'b0;
            last_addr  <= '0;
        end else begin
            mem_we <= 1'b0;
            unique case (st)
                CAP_IDLE, CAP_DONE: begin
                    if (accept) begin
                        skip_left  <= skip_in;
                        store_left <= count_in;
                        wr_addr    <= first_in;
                        base_addr  <= first_in;
                        if (count_in == '0) last_addr <= first_in;
                    end
                end
                CAP_DISCARD: begin
                    if (smp_valid) skip_left <= skip_left - ONE;
                end
                CAP_STORE: begin
                    if (smp_valid) begin
                        mem_we     <= 1'b1;
                        mem_addr   <= wr_addr;
                        mem_data   <= smp_data;
                        wr_addr    <= wr_addr + 1'b1;
                        store_left <= store_left - ONE;
                        if (store_left == ONE) last_addr <= wr_addr;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (st == CAP_DISCARD) || (st == CAP_STORE);
    assign done = (st == CAP_DONE);

    // R4: a write only follows a valid sample seen in the store state
    p_write_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(st == CAP_STORE && smp_valid));
    // R6: back-to-back writes step by one, wrapping modulo depth
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1);
    // R8: zero store count goes to done with no write
    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && count_in == '0 |=> done && !mem_we);
    // R9: a trigger while busy leaves the latched base alone
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trig_rise |=> base_addr == $past(base_addr));
    // R10: done holds until a trigger edge
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !trig_rise |=> done && !mem_we);
endmodule

// File: rtl/wave_capture_ctrl.sv
module wave_capture_ctrl #(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int CW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_in,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic [CW-1:0] skip_cnt,
    input  logic [AW-1:0] first_addr,
    input  logic [CW-1:0] store_cnt,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] last_addr
);
    logic trig_rise;

    wave_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_rise  (trig_rise)
    );

    wave_capture_fsm #(.DW(DW), .AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_rise (trig_rise),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .skip_in   (skip_cnt),
        .first_in  (first_addr),
        .count_in  (store_cnt),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done),
        .last_addr (last_addr)
    );

    // R11: the two status flags are exclusive at the ports
    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: tb/wave_capture_ctrl_tb.sv
module wave_capture_ctrl_tb;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int CW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [CW-1:0] skip_cnt = '0;
    logic [AW-1:0] first_addr = '0;
    logic [CW-1:0] store_cnt = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_we;
    logic          busy;
    logic          done;
    logic [AW-1:0] last_addr;

    int n_checks = 0;
    int n_fail = 0;
    int wr_total = 0;
    int cycles = 0;
    logic finished = 1'b0;

    logic [DW-1:0] mem_model [DEPTH];
    logic [DW-1:0] exp_mem   [DEPTH];

    always #2 clk = ~clk;

    wave_capture_ctrl #(.DW(DW), .AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .skip_cnt(skip_cnt), .first_addr(first_addr), .store_cnt(store_cnt),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
        .busy(busy), .done(done), .last_addr(last_addr)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[mem_addr] <= mem_data;
            wr_total <= wr_total + 1;
        end
    end

    function automatic logic [AW-1:0] exp_last(input int first, input int cnt);
        if (cnt == 0) return AW'(first);
        return AW'((first + cnt - 1) % DEPTH);
    endfunction

    function automatic logic [DW-1:0] sample_val(input int run, input int k);
        return DW'((run * 997 + k * 37) ^ 16'h5A3C);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // one capture; bad_trig pulses a second trigger and new config mid-run
    task automatic run_capture(input int run, input int skip, input int first,
                               input int cnt, input logic bad_trig);
        int vcount;
        int target;
        int mism;
        for (int a = 0; a < DEPTH; a++) begin
            mem_model[a] = 16'hDEAD;
            exp_mem[a]   = 16'hDEAD;
        end
        @(negedge clk);
        wr_total   = 0;
        skip_cnt   = CW'(skip);
        first_addr = AW'(first);
        store_cnt  = CW'(cnt);
        trig_in    = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        // R2 / R8 / R10: started within the synchronizer latency
        if (cnt == 0)
            check(done && !busy, "R8", {busy, done}, 1);
        else
            check(busy && !done, "R2", {busy, done}, 2);
        vcount = 0;
        target = skip + cnt + 3;
        while (vcount < target) begin
            smp_valid = ($urandom % 4) != 0;
            smp_data  = sample_val(run, vcount);
            if (bad_trig && vcount == skip + 1) begin
                trig_in    = 1'b1;
                first_addr = AW'(first + 17);
                store_cnt  = CW'(3);
                skip_cnt   = CW'(0);
            end
            if (bad_trig && vcount == skip + 5) trig_in = 1'b0;
            if (smp_valid) begin
                if (vcount >= skip && vcount < skip + cnt)
                    exp_mem[(first + vcount - skip) % DEPTH] = smp_data;
                vcount++;
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        trig_in   = 1'b0;
        repeat (3) @(negedge clk);
        check(done, "R10", done, 1);
        check(!busy, "R11", busy, 0);
        check(wr_total == cnt, bad_trig ? "R9" : "R5", wr_total, cnt);
        check(last_addr == exp_last(first, cnt), "R7", last_addr, exp_last(first, cnt));
        mism = 0;
        for (int a = 0; a < DEPTH; a++)
            if (mem_model[a] !== exp_mem[a]) mism++;
        // R3 discarded samples absent, R4 order, R6 wrap
        check(mism == 0, "R3/R4/R6 contents", mism, 0);
        repeat (5) @(negedge clk);
        check(done && !mem_we, "R10 hold", done, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog", cycles, 150000);
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_we, "R1 flags", {busy, done, mem_we}, 0);
        check(last_addr == '0, "R1 last_addr", last_addr, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        run_capture(1, 0, 10, 5, 1'b0);    // no discard, R4
        run_capture(2, 4, 0, 12, 1'b0);    // discard, R3
        run_capture(3, 2, 58, 10, 1'b0);   // wrap, R6
        run_capture(4, 3, 20, 0, 1'b0);    // zero count, R8
        run_capture(5, 1, 7, 9, 1'b0);     // clears done, R10
        run_capture(6, 2, 30, 12, 1'b1);   // trigger ignored while busy, R9
        run_capture(7, 0, 63, 1, 1'b0);    // single sample at top address
        for (int r = 0; r < 10; r++)
            run_capture(10 + r, $urandom % 6, $urandom % DEPTH, 1 + ($urandom % 40), 1'b0);
        summary();
    end
endmodule